// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block holds the three timers that an embedded processor core keeps next to its pipeline. A free-running timebase counter advances on each `tb_tick` pulse. A fixed-interval timer fires on the rising edge of one of four timebase bits. A programmable down-counter fires after a loaded number of ticks and can reload itself. A watchdog counts its own periods and escalates through three stages: it arms, then interrupts, then requests a reset.

Software reaches the unit through a single-cycle register port. `reg_sel` 0 selects the control word, 1 selects the status word and 2 selects the programmable counter. Select value 3 reads zero and ignores writes. Each timer reports through a status bit that software clears by writing 1 to it. An interrupt request is driven while both the status bit and its enable are set. A latched reset type drives the reset request outputs, and the core or chip carries out the reset.

Top module: `emb_timer_unit`

## Requirements
- R1: The control word keeps bits 31:22 and reads bits 21:0 as zero. Its fields are: 31:30 watchdog period select, 29:28 watchdog reset type, 27 watchdog interrupt enable, 26 counter interrupt enable, 25:24 fixed-timer period select, 23 fixed-timer interrupt enable, 22 counter auto-reload.
- R2: The status word keeps bits 31:26 and reads bits 25:0 as zero. Its fields are: 31 watchdog armed, 30 watchdog interrupt pending, 29:28 latched reset type, 27 counter expired, 26 fixed timer expired. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R3: With period select s, the fixed timer expires when timebase bit FIT_BASE+4*s rises, and expiry sets status bit 26. After reset the first expiry comes on tick 2^(FIT_BASE+4*s).
- R4: Writing a nonzero value N to the counter loads it and starts it. Status bit 27 sets on the N-th tick after the write, and the counter then reads 0 and stays stopped unless auto-reload is on. Writing 0 stops the counter without an expiry.
- R5: With auto-reload on, an expiring counter is loaded again with the last nonzero value written, and it expires again after that many further ticks.
- R6: With period select s, the watchdog period ends when timebase bit WDG_BASE+4*s rises. The first period ends on tick 2^(WDG_BASE+4*s) after reset.
- R7: At the end of a watchdog period the unit acts on status bits 31:30. If bit 31 is clear, bit 31 is set. Otherwise, if bit 30 is clear, bit 30 is set. If both bits are set, the control reset type is copied into status bits 29:28.
- R8: `rst_req` is high while status bits 29:28 are nonzero, and `rst_kind` shows them: 1 is a core reset, 2 a chip reset, 3 a system reset. Type 0 requests nothing.
- R9: `fit_irq`, `pit_irq` and `wdog_irq` are each high exactly while their status bit (26, 27, 30) and their enable (23, 26, 27) are both set.
- R10: After reset the control word, status word, counter, timebase and all request outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Timebase advance strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| fit_irq | output | 1 | Fixed-timer interrupt request |
| pit_irq | output | 1 | Programmable-counter interrupt request |
| wdog_irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | Reset request |
| rst_kind | output | 2 | Requested reset type |

## Verification
Properties are checked on every cycle. The zero bits of the control word must read as zero. A new expiry status may appear only after a tick, and a counter expiry only from a count of one. The counter must decrement by exactly one on an undisturbed tick. The watchdog interrupt stage and the reset stage may each be entered only from the stage before it. The exact tick on which each period selection expires, the reset type reported for each setting, and write-one-to-clear against write-zero can only be shown by the bench's sweeps, which count ticks from reset.

// File: rtl/emb_timer_unit.sv
`timescale 1ns/1ps
module emb_timer_unit #(
  parameter int TBW      = 32,
  parameter int FIT_BASE = 9,
  parameter int WDG_BASE = 17,
  parameter int PIT_W    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tb_tick,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        fit_irq,
  output logic        pit_irq,
  output logic        wdog_irq,
  output logic        rst_req,
  output logic [1:0]  rst_kind
);
  localparam int IW = $clog2(TBW);

  logic [TBW-1:0]   tb_q, tb_nx;
  logic [9:0]       ctrl_q;
  logic [5:0]       st_q, st_d;
  logic [PIT_W-1:0] pit_cnt_q, pit_rld_q;
  logic [IW-1:0]    fit_idx, wdg_idx;
  logic             fit_exp, wdg_exp, pit_exp, pit_wr;

  assign tb_nx   = tb_q + TBW'(1);
  assign fit_idx = IW'(FIT_BASE) + IW'({ctrl_q[3:2], 2'b00});
  assign wdg_idx = IW'(WDG_BASE) + IW'({ctrl_q[9:8], 2'b00});
  assign fit_exp = tb_tick & ~tb_q[fit_idx] & tb_nx[fit_idx];
  assign wdg_exp = tb_tick & ~tb_q[wdg_idx] & tb_nx[wdg_idx];
  assign pit_wr  = reg_we && reg_sel == 2'd2;
  assign pit_exp = tb_tick && !pit_wr && pit_cnt_q == PIT_W'(1);

  always_comb begin
    st_d = st_q;
    if (reg_we && reg_sel == 2'd1) st_d = st_q & ~reg_wdata[31:26];
    if (fit_exp) st_d[0] = 1'b1;
    if (pit_exp) st_d[1] = 1'b1;
    if (wdg_exp) begin
      if (!st_q[5])      st_d[5]   = 1'b1;
      else if (!st_q[4]) st_d[4]   = 1'b1;
      else               st_d[3:2] = ctrl_q[7:6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_q      <= '0;
      ctrl_q    <= '0;
      st_q      <= '0;
      pit_cnt_q <= '0;
      pit_rld_q <= '0;
    end else begin
      if (tb_tick) tb_q <= tb_nx;
      if (reg_we && reg_sel == 2'd0) ctrl_q <= reg_wdata[31:22];
      st_q <= st_d;
      if (pit_wr) begin
        pit_cnt_q <= reg_wdata[PIT_W-1:0];
        if (reg_wdata[PIT_W-1:0] != '0) pit_rld_q <= reg_wdata[PIT_W-1:0];
      end else if (pit_exp) begin
        pit_cnt_q <= ctrl_q[0] ? pit_rld_q : '0;
      end else if (tb_tick && pit_cnt_q != '0) begin
        pit_cnt_q <= pit_cnt_q - PIT_W'(1);
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {ctrl_q, 22'b0};
      2'd1:    reg_rdata = {st_q, 26'b0};
      2'd2:    reg_rdata = 32'(pit_cnt_q);
      default: reg_rdata = '0;
    endcase
  end

  assign fit_irq  = st_q[0] & ctrl_q[1];
  assign pit_irq  = st_q[1] & ctrl_q[4];
  assign wdog_irq = st_q[4] & ctrl_q[5];
  assign rst_kind = st_q[3:2];
  assign rst_req  = |st_q[3:2];
endmodule

// File: rtl/emb_timer_unit_chk.sv
`timescale 1ns/1ps
module emb_timer_unit_chk #(
  parameter int PIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tb_tick,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [31:0]      reg_rdata,
  input logic [5:0]       st,
  input logic [PIT_W-1:0] pit_cnt,
  input logic             rst_req
);
  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd0 |-> reg_rdata[21:0] == 22'b0); // R1
  AST_FIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[0]) |-> $past(tb_tick)); // R3
  AST_PIT_EXP_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[1]) |-> $past(pit_cnt) == PIT_W'(1)); // R4
  AST_PIT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick && !(reg_we && reg_sel == 2'd2) && pit_cnt > PIT_W'(1))
      |=> pit_cnt == $past(pit_cnt) - PIT_W'(1)); // R4
  AST_WDG_INT_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[4]) |-> $past(st[5])); // R7
  AST_RST_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(st[5] && st[4])); // R8
endmodule

bind emb_timer_unit emb_timer_unit_chk #(.PIT_W(PIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .st(st_q),
  .pit_cnt(pit_cnt_q), .rst_req(rst_req)
);

// File: tb/emb_timer_unit_tb_top.sv
`timescale 1ns/1ps
module emb_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fit_irq, pit_irq, wdog_irq, rst_req;
  logic [1:0]  rst_kind;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  emb_timer_unit #(.TBW(16), .FIT_BASE(1), .WDG_BASE(2), .PIT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fit_irq(fit_irq), .pit_irq(pit_irq), .wdog_irq(wdog_irq),
    .rst_req(rst_req), .rst_kind(rst_kind)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk); tb_tick = 1'b1;
    repeat (n) @(negedge clk);
    tb_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b;
    do_reset();
    // R10 reset state
    rd(2'd0, v); chk("R10 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R10 status", v, 32'h0);
    rd(2'd2, v); chk("R10 pit", v, 32'h0);
    chk("R10 outputs", {27'b0, fit_irq, pit_irq, wdog_irq, rst_req, 1'b0} | 32'(rst_kind), 32'h0);

    // R1 control mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R1 ctrl mask", v, 32'hFFC0_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R1 unused select", v, 32'h0);

    // R3 fixed timer period sweep, R2 clear, R9 gating
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(2'd0, (32'(s) << 24) | ((s % 2 == 0) ? 32'h0080_0000 : 32'h0));
      b = 1 + 4 * s;
      tick((1 << b) - 1);
      rd(2'd1, v); chk($sformatf("R3 fit before s=%0d", s), v & 32'h0400_0000, 32'h0);
      tick(1);
      rd(2'd1, v); chk($sformatf("R3 fit at s=%0d", s), v & 32'h0400_0000, 32'h0400_0000);
      chk($sformatf("R2 status low zero s=%0d", s), v & 32'h03FF_FFFF, 32'h0);
      chk($sformatf("R9 fit_irq s=%0d", s), 32'(fit_irq), (s % 2 == 0) ? 32'h1 : 32'h0);
      wr(2'd1, 32'h0);
      rd(2'd1, v); chk($sformatf("R2 write zero keeps s=%0d", s), v & 32'h0400_0000, 32'h0400_0000);
      wr(2'd1, 32'h0400_0000);
      rd(2'd1, v); chk($sformatf("R2 write one clears s=%0d", s), v & 32'h0400_0000, 32'h0);
      chk($sformatf("R9 fit_irq cleared s=%0d", s), 32'(fit_irq), 32'h0);
    end

    // R6 watchdog period sweep
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(2'd0, 32'(s) << 30);
      b = 2 + 4 * s;
      tick((1 << b) - 1);
      rd(2'd1, v); chk($sformatf("R6 wdg before s=%0d", s), v & 32'h8000_0000, 32'h0);
      tick(1);
      rd(2'd1, v); chk($sformatf("R6 wdg at s=%0d", s), v & 32'h8000_0000, 32'h8000_0000);
    end

    // R7 stages, R8 reset types
    for (int t = 0; t < 4; t++) begin
      do_reset();
      wr(2'd0, (32'(t) << 28) | 32'h0800_0000);
      tick(4);
      rd(2'd1, v); chk($sformatf("R7 stage1 t=%0d", t), v & 32'hF000_0000, 32'h8000_0000);
      chk($sformatf("R9 wdog_irq off t=%0d", t), 32'(wdog_irq), 32'h0);
      tick(8);
      rd(2'd1, v); chk($sformatf("R7 stage2 t=%0d", t), v & 32'hF000_0000, 32'hC000_0000);
      chk($sformatf("R9 wdog_irq on t=%0d", t), 32'(wdog_irq), 32'h1);
      chk($sformatf("R8 no req yet t=%0d", t), 32'(rst_req), 32'h0);
      tick(8);
      rd(2'd1, v); chk($sformatf("R7 stage3 t=%0d", t), v & 32'hF000_0000, 32'hC000_0000 | (32'(t) << 28));
      chk($sformatf("R8 rst_kind t=%0d", t), 32'(rst_kind), 32'(t));
      chk($sformatf("R8 rst_req t=%0d", t), 32'(rst_req), (t != 0) ? 32'h1 : 32'h0);
      wr(2'd1, 32'h3000_0000);
      chk($sformatf("R8 req cleared t=%0d", t), 32'(rst_req), 32'h0);
    end

    // R4 one-shot counter and stop
    do_reset();
    wr(2'd0, 32'h0400_0000);
    wr(2'd2, 32'd5);
    rd(2'd2, v); chk("R4 loaded", v, 32'd5);
    tick(4);
    rd(2'd2, v); chk("R4 count", v, 32'd1);
    rd(2'd1, v); chk("R4 not yet", v & 32'h0800_0000, 32'h0);
    tick(1);
    rd(2'd1, v); chk("R4 expired", v & 32'h0800_0000, 32'h0800_0000);
    chk("R9 pit_irq", 32'(pit_irq), 32'h1);
    tick(10);
    rd(2'd2, v); chk("R4 stays stopped", v, 32'h0);
    wr(2'd1, 32'h0800_0000);
    wr(2'd2, 32'd7);
    tick(3);
    wr(2'd2, 32'd0);
    tick(10);
    rd(2'd1, v); chk("R4 stop no expiry", v & 32'h0800_0000, 32'h0);
    rd(2'd2, v); chk("R4 stop reads zero", v, 32'h0);

    // R5 auto-reload
    do_reset();
    wr(2'd0, 32'h0440_0000);
    wr(2'd2, 32'd3);
    tick(3);
    rd(2'd1, v); chk("R5 first expiry", v & 32'h0800_0000, 32'h0800_0000);
    rd(2'd2, v); chk("R5 reloaded", v, 32'd3);
    wr(2'd1, 32'h0800_0000);
    tick(2);
    rd(2'd1, v); chk("R5 before second", v & 32'h0800_0000, 32'h0);
    tick(1);
    rd(2'd1, v); chk("R5 second expiry", v & 32'h0800_0000, 32'h0800_0000);
    wr(2'd0, 32'h0040_0000);
    chk("R9 pit_irq disabled", 32'(pit_irq), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule